// File: doc/BRIEF.md
# Flash Sector Write Host Controller

This block sits on the host side of a flash memory that is programmed one whole sector at a time. On a start request it takes a sector number, fetches a sector's worth of bytes from a local buffer through an index/data read port, and drives the flash strobes, address and data pins through one byte-load cycle per byte. The loads follow each other at a fixed spacing in clock cycles. That spacing is checked at elaboration to be shorter than the window after which the flash would close the load phase and start its internal erase-and-program cycle on its own.

Once the last byte is loaded, the controller reads back the last address of the sector over and over until the flash reports that programming has finished. It can tell this in one of two ways, chosen per operation. In data polling, the top data bit must match the top bit that was written. In toggle polling, the next-to-top bit must stop alternating between two reads in a row. The read that ends the polling is then compared in full against the byte that was written. The controller signals completion with a one-cycle done pulse, with a verify-error flag in the same cycle when the comparison fails. A watchdog ends the polling with a one-cycle timeout pulse if completion never shows up. All strobe widths, the read access delay, the polling limit and the field widths are parameters.

Top module: `fsw_ctrl`

## Requirements
- R1: After reset, and whenever busy_o is low, fl_ce_n_o, fl_we_n_o and fl_oe_n_o are high, fl_doe_o is low, and done_o, timeout_o and verify_err_o are low.
- R2: Each byte load holds fl_we_n_o low for exactly WE_LOW_CYC cycles. During that time fl_ce_n_o is low, fl_oe_n_o is high, fl_doe_o is high, and fl_addr_o and fl_dout_o do not change.
- R3: One operation loads every byte index 0 to 2^IDX_W-1 exactly once, in ascending order. The sector number sits on the upper address bits fl_addr_o[ADDR_W-1:IDX_W] and the index on fl_addr_o[IDX_W-1:0]. The byte written is the value buf_data_i returns for buf_addr_o equal to that index, and the sector bits stay fixed for the whole operation.
- R4: Falling edges of fl_we_n_o for consecutive loads are exactly 1+WE_LOW_CYC+WE_HIGH_CYC cycles apart. That spacing must be smaller than LOAD_WINDOW_CYC.
- R5: With poll_mode_i=0 at start (data polling), the controller completes only on a read of the sector's last index whose bit DW-1 equals bit DW-1 of the byte written there. It does so whatever bit DW-2 does.
- R6: With poll_mode_i=1 at start (toggle polling), the controller completes only when bit DW-2 has the same value on two consecutive reads. It does so whatever bit DW-1 shows.
- R7: Each status read holds fl_ce_n_o and fl_oe_n_o low, fl_we_n_o high and fl_doe_o low for ACCESS_CYC cycles, and samples fl_din_i at the end of that time.
- R8: If completion is not seen within POLL_LIMIT cycles of the first status read, timeout_o pulses for one cycle, done_o stays low, and the controller returns to idle.
- R9: On completion done_o pulses for exactly one cycle. verify_err_o is high in that same cycle exactly when the completing read differs from the byte written at the last index.
- R10: start_i is accepted only while busy_o is low. busy_o goes high the cycle after acceptance and stays high up to and including the done or timeout cycle. A start_i pulse while busy_o is high changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to program one sector |
| sector_i | input | SECT_W | Sector number, captured at start |
| poll_mode_i | input | 1 | 0 = data polling, 1 = toggle polling, captured at start |
| buf_addr_o | output | IDX_W | Byte index presented to the payload buffer |
| buf_data_i | input | DW | Payload byte for buf_addr_o (combinational read) |
| fl_addr_o | output | SECT_W+IDX_W | Flash address: sector above, byte index below |
| fl_dout_o | output | DW | Data driven to the flash |
| fl_doe_o | output | 1 | Enables the flash data pin drivers |
| fl_din_i | input | DW | Data read from the flash |
| fl_ce_n_o | output | 1 | Flash chip select, active low |
| fl_we_n_o | output | 1 | Flash write enable, active low |
| fl_oe_n_o | output | 1 | Flash output enable, active low |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| verify_err_o | output | 1 | With done_o: the final read did not match |
| timeout_o | output | 1 | One-cycle polling timeout pulse |

## Verification
The assertions check the pin framing on every cycle. A load never overlaps a read. Address and data hold still while write enable is low. The sector bits do not move during an operation, and the pins rest when idle. done, timeout and verify-error keep their one-cycle, mutually exclusive pulse shape. The bench scenarios show what needs a flash model to see. Every index is loaded once with the right byte at the exact spacing. Data polling ignores a frozen toggle bit, and toggle polling ignores a misleading top bit. Both finish only after the model stops reporting busy. The watchdog fires near its limit, and a corrupted final read raises verify-error. A start pulse mid-operation leaves the load sequence untouched.

// File: rtl/fsw_pkg.sv
package fsw_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_LD_SET,
      S_LD_LOW,
      S_LD_HIGH,
      S_RD_ACC,
      S_RD_EVAL,
      S_DONE,
      S_TMO
   } fsw_state_e;

   typedef enum logic {
      POLL_DATA   = 1'b0,
      POLL_TOGGLE = 1'b1
   } fsw_poll_e;
endpackage

// File: rtl/fsw_phase_timer.sv
// Down-counter that times one strobe phase; zero_o marks the phase's last cycle.
module fsw_phase_timer #(
   parameter int TW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [TW-1:0] val_i,
   output logic          zero_o
);
   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load_i)         cnt_q <= val_i;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/fsw_watchdog.sv
// Counts polling cycles; a LIMIT of zero removes the watchdog entirely.
module fsw_watchdog #(
   parameter int LIMIT = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic expired_o
);
   generate
      if (LIMIT == 0) begin : g_off
         assign expired_o = 1'b0;
      end else begin : g_on
         localparam int CW = $clog2(LIMIT + 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    cnt_q <= '0;
            else if (!run_i)               cnt_q <= '0;
            else if (cnt_q != CW'(LIMIT))  cnt_q <= cnt_q + 1'b1;
         end

         assign expired_o = (cnt_q == CW'(LIMIT));
      end
   endgenerate
endmodule

// File: rtl/fsw_poll_eval.sv
// Judges one status read: completion per polling method, and a full-byte compare.
module fsw_poll_eval
   import fsw_pkg::*;
#(
   parameter int DW = 8
) (
   input  fsw_poll_e       mode_i,
   input  logic [DW-1:0]   rd_i,
   input  logic            prev_tog_i,
   input  logic            prev_vld_i,
   input  logic [DW-1:0]   expect_i,
   output logic            done_o,
   output logic            mismatch_o
);
   localparam int POLL_BIT = DW - 1;
   localparam int TOG_BIT  = DW - 2;

   always_comb begin
      if (mode_i == POLL_TOGGLE) done_o = prev_vld_i && (rd_i[TOG_BIT] == prev_tog_i);
      else                       done_o = (rd_i[POLL_BIT] == expect_i[POLL_BIT]);
   end

   assign mismatch_o = (rd_i != expect_i);
endmodule

// File: rtl/fsw_ctrl.sv
module fsw_ctrl
   import fsw_pkg::*;
#(
   parameter int SECT_W          = 10,
   parameter int IDX_W           = 7,
   parameter int DW              = 8,
   parameter int WE_LOW_CYC      = 4,
   parameter int WE_HIGH_CYC     = 3,
   parameter int ACCESS_CYC      = 3,
   parameter int LOAD_WINDOW_CYC = 7500,
   parameter int POLL_LIMIT      = 500000
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start_i,
   input  logic [SECT_W-1:0]        sector_i,
   input  logic                     poll_mode_i,
   output logic [IDX_W-1:0]         buf_addr_o,
   input  logic [DW-1:0]            buf_data_i,
   output logic [SECT_W+IDX_W-1:0]  fl_addr_o,
   output logic [DW-1:0]            fl_dout_o,
   output logic                     fl_doe_o,
   input  logic [DW-1:0]            fl_din_i,
   output logic                     fl_ce_n_o,
   output logic                     fl_we_n_o,
   output logic                     fl_oe_n_o,
   output logic                     busy_o,
   output logic                     done_o,
   output logic                     verify_err_o,
   output logic                     timeout_o
);
   localparam int ADDR_W   = SECT_W + IDX_W;
   localparam int LOAD_GAP = 1 + WE_LOW_CYC + WE_HIGH_CYC;
   localparam int TMAX0    = (WE_LOW_CYC > WE_HIGH_CYC) ? WE_LOW_CYC : WE_HIGH_CYC;
   localparam int TMAX     = (TMAX0 > ACCESS_CYC) ? TMAX0 : ACCESS_CYC;
   localparam int TW       = $clog2(TMAX + 1);
   localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

   // Elaboration-time parameter checks
   if (WE_LOW_CYC < 1)  begin : g_bad_wl  $error("WE_LOW_CYC must be at least 1");  end
   if (WE_HIGH_CYC < 1) begin : g_bad_wh  $error("WE_HIGH_CYC must be at least 1"); end
   if (ACCESS_CYC < 1)  begin : g_bad_acc $error("ACCESS_CYC must be at least 1");  end
   if (DW < 2)          begin : g_bad_dw  $error("DW must be at least 2");          end
   if (LOAD_GAP >= LOAD_WINDOW_CYC) begin : g_bad_gap
      $error("load spacing does not fit the load window");
   end

   fsw_state_e state_q, state_d;
   fsw_poll_e  mode_q;
   logic [SECT_W-1:0] sect_q;
   logic [IDX_W-1:0]  idx_q;
   logic [DW-1:0]     dout_q, last_q, rd_q;
   logic              prev_tog_q, prev_vld_q, verr_q;

   logic          tmr_load, tmr_zero;
   logic [TW-1:0] tmr_val;
   logic          wd_run, wd_exp;
   logic          ev_done, ev_mis;

   // Next state
   always_comb begin
      state_d = state_q;
      unique case (state_q)
         S_IDLE:    if (start_i)  state_d = S_LD_SET;
         S_LD_SET:                state_d = S_LD_LOW;
         S_LD_LOW:  if (tmr_zero) state_d = S_LD_HIGH;
         S_LD_HIGH: if (tmr_zero) state_d = (idx_q == LAST_IDX) ? S_RD_ACC : S_LD_SET;
         S_RD_ACC:  if (tmr_zero) state_d = S_RD_EVAL;
         S_RD_EVAL: begin
            if (ev_done)     state_d = S_DONE;
            else if (wd_exp) state_d = S_TMO;
            else             state_d = S_RD_ACC;
         end
         S_DONE, S_TMO:      state_d = S_IDLE;
         default:            state_d = S_IDLE;
      endcase
   end

   // Phase timer reload on every state change
   always_comb begin
      unique case (state_d)
         S_LD_LOW:  tmr_val = TW'(WE_LOW_CYC - 1);
         S_LD_HIGH: tmr_val = TW'(WE_HIGH_CYC - 1);
         S_RD_ACC:  tmr_val = TW'(ACCESS_CYC - 1);
         default:   tmr_val = '0;
      endcase
   end
   assign tmr_load = (state_d != state_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= S_IDLE;
         mode_q     <= POLL_DATA;
         sect_q     <= '0;
         idx_q      <= '0;
         dout_q     <= '0;
         last_q     <= '0;
         rd_q       <= '0;
         prev_tog_q <= 1'b0;
         prev_vld_q <= 1'b0;
         verr_q     <= 1'b0;
      end else begin
         state_q <= state_d;
         unique case (state_q)
            S_IDLE: if (start_i) begin
               sect_q     <= sector_i;
               mode_q     <= fsw_poll_e'(poll_mode_i);
               idx_q      <= '0;
               prev_vld_q <= 1'b0;
               verr_q     <= 1'b0;
            end
            S_LD_SET: begin
               dout_q <= buf_data_i;
               if (idx_q == LAST_IDX) last_q <= buf_data_i;
            end
            S_LD_HIGH: if (tmr_zero && idx_q != LAST_IDX) idx_q <= idx_q + 1'b1;
            S_RD_ACC:  if (tmr_zero) rd_q <= fl_din_i;
            S_RD_EVAL: begin
               prev_tog_q <= rd_q[DW-2];
               prev_vld_q <= 1'b1;
               verr_q     <= ev_mis;
            end
            default: ;
         endcase
      end
   end

   fsw_phase_timer #(.TW(TW)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (tmr_load),
      .val_i  (tmr_val),
      .zero_o (tmr_zero)
   );

   assign wd_run = (state_q == S_RD_ACC) || (state_q == S_RD_EVAL);

   fsw_watchdog #(.LIMIT(POLL_LIMIT)) u_wd (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (wd_run),
      .expired_o (wd_exp)
   );

   fsw_poll_eval #(.DW(DW)) u_eval (
      .mode_i     (mode_q),
      .rd_i       (rd_q),
      .prev_tog_i (prev_tog_q),
      .prev_vld_i (prev_vld_q),
      .expect_i   (last_q),
      .done_o     (ev_done),
      .mismatch_o (ev_mis)
   );

   // Pin decode from state
   assign buf_addr_o   = idx_q;
   assign fl_addr_o    = {sect_q, idx_q};
   assign fl_dout_o    = dout_q;
   assign fl_doe_o     = (state_q == S_LD_SET) || (state_q == S_LD_LOW) || (state_q == S_LD_HIGH);
   assign fl_ce_n_o    = !(fl_doe_o || state_q == S_RD_ACC);
   assign fl_we_n_o    = (state_q != S_LD_LOW);
   assign fl_oe_n_o    = (state_q != S_RD_ACC);
   assign busy_o       = (state_q != S_IDLE);
   assign done_o       = (state_q == S_DONE);
   assign verify_err_o = (state_q == S_DONE) && verr_q;
   assign timeout_o    = (state_q == S_TMO);

   wire unused_addr_w = ^{ADDR_W[0]};
endmodule

// File: rtl/fsw_ctrl_chk.sv
module fsw_ctrl_chk #(
   parameter int SECT_W = 10,
   parameter int IDX_W  = 7,
   parameter int DW     = 8
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     start_i,
   input logic [SECT_W+IDX_W-1:0]  fl_addr_o,
   input logic [DW-1:0]            fl_dout_o,
   input logic                     fl_doe_o,
   input logic                     fl_ce_n_o,
   input logic                     fl_we_n_o,
   input logic                     fl_oe_n_o,
   input logic                     busy_o,
   input logic                     done_o,
   input logic                     verify_err_o,
   input logic                     timeout_o
);
   localparam int ADDR_W = SECT_W + IDX_W;

   assert_idle_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> fl_ce_n_o && fl_we_n_o && fl_oe_n_o && !fl_doe_o && !done_o && !timeout_o);

   assert_load_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_we_n_o |-> !fl_ce_n_o && fl_oe_n_o && fl_doe_o);

   assert_load_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!fl_we_n_o && $past(!fl_we_n_o)) |-> ($stable(fl_addr_o) && $stable(fl_dout_o)));

   assert_sector_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(fl_addr_o[ADDR_W-1:IDX_W]));

   assert_read_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_oe_n_o |-> !fl_ce_n_o && fl_we_n_o && !fl_doe_o);

   assert_timeout_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |=> !timeout_o && !busy_o);

   assert_no_both_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && timeout_o));

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o && !busy_o);

   assert_verr_in_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      verify_err_o |-> done_o);

   assert_start_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i) |=> busy_o);
endmodule

bind fsw_ctrl fsw_ctrl_chk #(.SECT_W(SECT_W), .IDX_W(IDX_W), .DW(DW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start_i      (start_i),
   .fl_addr_o    (fl_addr_o),
   .fl_dout_o    (fl_dout_o),
   .fl_doe_o     (fl_doe_o),
   .fl_ce_n_o    (fl_ce_n_o),
   .fl_we_n_o    (fl_we_n_o),
   .fl_oe_n_o    (fl_oe_n_o),
   .busy_o       (busy_o),
   .done_o       (done_o),
   .verify_err_o (verify_err_o),
   .timeout_o    (timeout_o)
);

// File: tb/sim_fsw_ctrl.sv
`timescale 1ns/1ps
module sim_fsw_ctrl;
   localparam int SECT_W = 10;
   localparam int IDX_W  = 7;
   localparam int DW     = 8;
   localparam int NB     = 128;
   localparam int WL     = 3;
   localparam int WH     = 2;
   localparam int ACC    = 2;
   localparam int WIN    = 20;
   localparam int LIMIT  = 400;
   localparam int GAP    = 1 + WL + WH;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic [SECT_W-1:0] sector_i = '0;
   logic poll_mode_i = 1'b0;
   logic [IDX_W-1:0] buf_addr_o;
   logic [DW-1:0] buf_data_i;
   logic [SECT_W+IDX_W-1:0] fl_addr_o;
   logic [DW-1:0] fl_dout_o, fl_din_i;
   logic fl_doe_o, fl_ce_n_o, fl_we_n_o, fl_oe_n_o;
   logic busy_o, done_o, verify_err_o, timeout_o;

   always #10 clk = ~clk;

   fsw_ctrl #(.SECT_W(SECT_W), .IDX_W(IDX_W), .DW(DW), .WE_LOW_CYC(WL), .WE_HIGH_CYC(WH),
              .ACCESS_CYC(ACC), .LOAD_WINDOW_CYC(WIN), .POLL_LIMIT(LIMIT)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .sector_i(sector_i),
      .poll_mode_i(poll_mode_i), .buf_addr_o(buf_addr_o), .buf_data_i(buf_data_i),
      .fl_addr_o(fl_addr_o), .fl_dout_o(fl_dout_o), .fl_doe_o(fl_doe_o), .fl_din_i(fl_din_i),
      .fl_ce_n_o(fl_ce_n_o), .fl_we_n_o(fl_we_n_o), .fl_oe_n_o(fl_oe_n_o), .busy_o(busy_o),
      .done_o(done_o), .verify_err_o(verify_err_o), .timeout_o(timeout_o));

   // payload buffer and flash model state
   logic [DW-1:0] pat [NB];
   logic [DW-1:0] mem [NB];
   int hits [NB];
   assign buf_data_i = pat[buf_addr_o];

   int n_chk = 0, n_bad = 0;
   bit finished = 0;
   int cyc = 0;
   logic [SECT_W-1:0] exp_sect;
   int prog_len;
   bit stuck, dq7_true, tog_freeze;
   logic [DW-1:0] corrupt;
   bit model_busy, tog;
   int busy_cnt, ready_cyc;
   int loads, reads, bad_addr, bad_data, bad_space, bad_width, bad_stable, bad_strobe;
   int done_cnt, verr_cnt, tmo_cnt, done_cyc, tmo_cyc, last_rise, last_fall, low_start;
   bit have_fall, prev_we, prev_oe;
   logic [SECT_W+IDX_W-1:0] fall_addr;
   logic [DW-1:0] fall_data, cur;

   always_comb begin
      cur = mem[fl_addr_o[IDX_W-1:0]];
      if (model_busy) fl_din_i = {dq7_true ? cur[DW-1] : ~cur[DW-1], tog, cur[DW-3:0]};
      else            fl_din_i = cur ^ corrupt;
   end

   always @(negedge clk) begin
      cyc = cyc + 1;
      if (prev_we && !fl_we_n_o) begin
         if (have_fall && (cyc - last_fall) != GAP) bad_space++;
         last_fall = cyc; have_fall = 1; low_start = cyc;
         fall_addr = fl_addr_o; fall_data = fl_dout_o;
      end
      if (!fl_we_n_o) begin
         if (fl_ce_n_o || !fl_oe_n_o || !fl_doe_o) bad_strobe++;
         if (fl_addr_o != fall_addr || fl_dout_o != fall_data) bad_stable++;
      end
      if (!prev_we && fl_we_n_o) begin
         if ((cyc - low_start) != WL) bad_width++;
         if (fl_addr_o[SECT_W+IDX_W-1:IDX_W] != exp_sect) bad_addr++;
         if (fl_addr_o[IDX_W-1:0] != IDX_W'(loads)) bad_addr++;
         if (fl_dout_o != pat[fl_addr_o[IDX_W-1:0]]) bad_data++;
         mem[fl_addr_o[IDX_W-1:0]] = fl_dout_o;
         hits[fl_addr_o[IDX_W-1:0]]++;
         loads++; last_rise = cyc;
         if (loads == NB) begin model_busy = 1; busy_cnt = prog_len; end
      end
      if (prev_oe && !fl_oe_n_o) begin
         reads++;
         if (!tog_freeze) tog = ~tog;
         if (!fl_we_n_o || fl_ce_n_o || fl_doe_o) bad_strobe++;
      end
      if (model_busy && !stuck) begin
         if (busy_cnt <= 1) begin model_busy = 0; ready_cyc = cyc; end
         busy_cnt--;
      end
      if (done_o) begin done_cnt++; done_cyc = cyc; if (verify_err_o) verr_cnt++; end
      if (timeout_o) begin tmo_cnt++; tmo_cyc = cyc; end
      prev_we = fl_we_n_o; prev_oe = fl_oe_n_o;
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic run_write(input logic [SECT_W-1:0] sect, input logic mode, input int prog,
                            input bit stk, input bit d7t, input bit tfz, input logic [DW-1:0] corr,
                            input bit glitch, input int seed);
      for (int i = 0; i < NB; i++) begin
         pat[i] = DW'(i * seed + 53) ^ DW'(seed << 3);
         mem[i] = '0; hits[i] = 0;
      end
      exp_sect = sect; prog_len = prog; stuck = stk; dq7_true = d7t; tog_freeze = tfz;
      corrupt = corr; model_busy = 0; tog = 0; ready_cyc = 0;
      loads = 0; reads = 0; bad_addr = 0; bad_data = 0; bad_space = 0; bad_width = 0;
      bad_stable = 0; bad_strobe = 0; done_cnt = 0; verr_cnt = 0; tmo_cnt = 0;
      have_fall = 0; done_cyc = 0; tmo_cyc = 0;
      @(negedge clk);
      sector_i = sect; poll_mode_i = mode; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o === 1'b1, "R10", "busy after start", int'(busy_o), 1);
      if (glitch) begin
         repeat (200) @(negedge clk);
         sector_i = ~sect; poll_mode_i = ~mode; start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
      end
      for (int k = 0; k < 5000; k++) begin
         if (done_cnt != 0 || tmo_cnt != 0) break;
         @(negedge clk);
      end
      repeat (40) @(negedge clk);
   endtask

   task automatic check_loads();
      int missing = 0;
      for (int i = 0; i < NB; i++) if (hits[i] != 1) missing++;
      chk(loads == NB, "R3", "load count", loads, NB);
      chk(missing == 0, "R3", "indices not loaded once", missing, 0);
      chk(bad_addr == 0, "R3", "wrong address on load", bad_addr, 0);
      chk(bad_data == 0, "R3", "wrong data on load", bad_data, 0);
      chk(bad_space == 0, "R4", "load edge spacing errors", bad_space, 0);
      chk(bad_width == 0, "R2", "write strobe width errors", bad_width, 0);
      chk(bad_stable == 0, "R2", "address/data moved under strobe", bad_stable, 0);
      chk(bad_strobe == 0, "R7", "strobe framing errors", bad_strobe, 0);
      chk(busy_o == 1'b0, "R1", "busy after finish", int'(busy_o), 0);
   endtask

   task automatic check_done(input string req);
      chk(done_cnt == 1, "R9", "done high cycles", done_cnt, 1);
      chk(tmo_cnt == 0, "R8", "timeout pulses", tmo_cnt, 0);
      chk(reads > 0, "R7", "status reads", reads, 1);
      chk(done_cyc > ready_cyc, req, "done after flash ready", done_cyc, ready_cyc + 1);
      chk(done_cyc <= ready_cyc + 2 * (ACC + 1) + 4, req, "done soon after ready",
          done_cyc - ready_cyc, 2 * (ACC + 1) + 4);
   endtask

   task automatic t_reset();
      chk(fl_ce_n_o && fl_we_n_o && fl_oe_n_o, "R1", "strobes idle high",
          int'({fl_ce_n_o, fl_we_n_o, fl_oe_n_o}), 7);
      chk(!busy_o && !done_o && !timeout_o && !verify_err_o && !fl_doe_o, "R1", "status idle",
          int'({busy_o, done_o, timeout_o, verify_err_o, fl_doe_o}), 0);
   endtask

   task automatic t_data_poll();
      run_write(10'd5, 1'b0, 150, 0, 0, 0, 8'h00, 0, 7);
      check_loads();
      check_done("R5");
      chk(verr_cnt == 0, "R9", "verify error on clean data", verr_cnt, 0);
   endtask

   task automatic t_data_poll_frozen_toggle();
      run_write(10'h2A7, 1'b0, 90, 0, 0, 1, 8'h00, 0, 13);
      check_loads();
      check_done("R5");
   endtask

   task automatic t_toggle();
      run_write(10'h3FF, 1'b1, 120, 0, 0, 0, 8'h00, 0, 29);
      check_loads();
      check_done("R6");
      chk(verr_cnt == 0, "R9", "verify error on clean data", verr_cnt, 0);
   endtask

   task automatic t_toggle_true_top_bit();
      run_write(10'h100, 1'b1, 200, 0, 1, 0, 8'h00, 0, 45);
      check_loads();
      check_done("R6");
   endtask

   task automatic t_start_while_busy();
      run_write(10'h0C3, 1'b0, 100, 0, 0, 0, 8'h00, 1, 3);
      check_loads();
      chk(done_cnt == 1, "R10", "ops completed after extra start", done_cnt, 1);
   endtask

   task automatic t_timeout();
      int d;
      run_write(10'h011, 1'b0, 0, 1, 0, 0, 8'h00, 0, 61);
      d = tmo_cyc - last_rise;
      chk(tmo_cnt == 1, "R8", "timeout pulses", tmo_cnt, 1);
      chk(done_cnt == 0, "R8", "done on timeout", done_cnt, 0);
      chk(d >= LIMIT && d <= LIMIT + 12, "R8", "cycles to timeout", d, LIMIT);
      chk(busy_o == 1'b0, "R8", "idle after timeout", int'(busy_o), 0);
   endtask

   task automatic t_verify_err();
      run_write(10'h155, 1'b0, 60, 0, 0, 0, 8'h01, 0, 91);
      check_loads();
      chk(done_cnt == 1, "R9", "done pulse with bad readback", done_cnt, 1);
      chk(verr_cnt == 1, "R9", "verify error flagged", verr_cnt, 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual=hung expected=finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      prev_we = 1; prev_oe = 1; corrupt = '0; model_busy = 0;
      for (int i = 0; i < NB; i++) begin pat[i] = '0; mem[i] = '0; hits[i] = 0; end
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      t_data_poll();
      t_data_poll_frozen_toggle();
      t_toggle();
      t_toggle_true_top_bit();
      t_start_while_busy();
      t_timeout();
      t_verify_err();
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule